// File: doc/BRIEF.md
# Overhead Byte Drop Serializer

This block sits behind a receive framer and picks a handful of fixed transport overhead bytes out of the byte-wide frame stream. The framer presents each overhead byte with a valid strobe and its row and column inside the overhead area, and it pulses a frame-start strobe once per frame. The block keeps the bytes it wants and sends them out on serial lines during the next frame.

There are three output groups. The orderwire and user-channel group has three data lines (one for each of the two orderwire bytes and one for the user-channel byte) that share one bit clock. It carries 8 bits per frame, which gives 64 kb/s at the standard frame rate. The section data channel carries three bytes per frame (192 kb/s) and has its own clock. The line data channel carries nine bytes per frame (576 kb/s) and also has its own clock. Each output clock is a gapped pulse train made from the system clock. It gives one pulse for each bit and stays low when nothing is pending. Data lines change only on the falling edge of their clock.

Top module: `ohd_drop_ser`

## Requirements
- R1: The byte at row 1 column 1 (first orderwire) goes out on `e1_sdata`. The byte at row 8 column 2 (second orderwire) goes out on `e2_sdata`. The byte at row 1 column 2 (user channel) goes out on `f1_sdata`. Each is sent most significant bit first during the frame that follows its capture, one bit for each rising edge of `ow_sclk`.
- R2: After a frame in which all three orderwire/user bytes were captured, `ow_sclk` gives exactly 8 rising edges in the next frame.
- R3: The section channel sends the bytes at row 2, columns 0, 1 and 2, in that order and MSB first, as 24 bits on `sdcc_sdata`, with 24 rising edges of `sdcc_sclk`.
- R4: The line channel sends the nine bytes at rows 5 to 7, columns 0 to 2, in row-major order and MSB first, as 72 bits on `ldcc_sdata`, with 72 rising edges of `ldcc_sclk`.
- R5: A data line never changes while its clock is high. It changes only in the cycle its clock falls, or when a new frame is loaded while the clock is low.
- R6: During reset all outputs are low. Each output clock stays low from reset until the first frame start, and it stays low after its bits are sent.
- R7: If a channel did not capture every one of its bytes in a frame, it gives no clock pulses in the next frame. The other channels are not affected.
- R8: A byte with `oh_valid` low, or a byte at any other row/column, has no effect on any output.
- R9: Bytes captured while the previous frame's data is still being shifted out do not change the bits that are going out.
- R10: Rising edges of a channel clock inside one frame are exactly the channel's period parameter apart, counted in system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oh_byte | input | 8 | Received overhead byte |
| oh_valid | input | 1 | `oh_byte` and its position are valid |
| oh_row | input | 4 | Overhead row of the byte (0 to 8) |
| oh_col | input | 4 | Overhead column of the byte (0 to 2) |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| ow_sclk | output | 1 | Shared gapped bit clock of the orderwire/user group |
| e1_sdata | output | 1 | First orderwire serial data |
| e2_sdata | output | 1 | Second orderwire serial data |
| f1_sdata | output | 1 | User-channel serial data |
| sdcc_sclk | output | 1 | Section data channel gapped clock |
| sdcc_sdata | output | 1 | Section data channel serial data |
| ldcc_sclk | output | 1 | Line data channel gapped clock |
| ldcc_sdata | output | 1 | Line data channel serial data |

## Verification
A wrong byte index or a wrong capture mask shows up one frame later, as wrong bits or a missing pulse train on the affected channel. A wrong bit counter shows up in the same frame as a pulse count other than 8, 24 or 72. A phase counter fault changes the spacing between rising edges, so the first two pulses of any burst reveal it. A shift taken at the wrong point changes a data line while its clock is high, and that is visible within one bit period.

// File: rtl/ohd_pkg.sv
package ohd_pkg;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int IDX_W = 4;

  // Fixed overhead positions of the dropped bytes
  localparam logic [ROW_W-1:0] OW1_ROW  = 4'd1;
  localparam logic [COL_W-1:0] OW1_COL  = 4'd1;
  localparam logic [ROW_W-1:0] USR_ROW  = 4'd1;
  localparam logic [COL_W-1:0] USR_COL  = 4'd2;
  localparam logic [ROW_W-1:0] OW2_ROW  = 4'd8;
  localparam logic [COL_W-1:0] OW2_COL  = 4'd2;
  localparam logic [ROW_W-1:0] SEC_ROW  = 4'd2;
  localparam logic [ROW_W-1:0] LIN_ROW0 = 4'd5;
  localparam logic [ROW_W-1:0] LIN_ROW1 = 4'd7;
  localparam logic [COL_W-1:0] COL_LAST = 4'd2;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } ohd_sel_t;
endpackage

// File: rtl/ohd_pos_decode.sv
module ohd_pos_decode
  import ohd_pkg::*;
(
  input  logic             oh_valid,
  input  logic [ROW_W-1:0] oh_row,
  input  logic [COL_W-1:0] oh_col,
  output ohd_sel_t         ow1_sel,
  output ohd_sel_t         ow2_sel,
  output ohd_sel_t         usr_sel,
  output ohd_sel_t         sec_sel,
  output ohd_sel_t         lin_sel
);
  logic             col_ok;
  logic [ROW_W-1:0] lin_rel;

  always_comb begin
    col_ok  = (oh_col <= COL_LAST);
    lin_rel = oh_row - LIN_ROW0;

    ow1_sel.hit = oh_valid && (oh_row == OW1_ROW) && (oh_col == OW1_COL);
    ow1_sel.idx = '0;
    ow2_sel.hit = oh_valid && (oh_row == OW2_ROW) && (oh_col == OW2_COL);
    ow2_sel.idx = '0;
    usr_sel.hit = oh_valid && (oh_row == USR_ROW) && (oh_col == USR_COL);
    usr_sel.idx = '0;

    sec_sel.hit = oh_valid && col_ok && (oh_row == SEC_ROW);
    sec_sel.idx = oh_col;

    lin_sel.hit = oh_valid && col_ok && (oh_row >= LIN_ROW0) && (oh_row <= LIN_ROW1);
    lin_sel.idx = lin_rel * 4'd3 + oh_col;
  end
endmodule

// File: rtl/ohd_ser_chan.sv
module ohd_ser_chan
  import ohd_pkg::*;
#(
  parameter int LANES  = 1,
  parameter int NBYTES = 3,
  parameter int PERIOD = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic [7:0]                  cap_byte,
  input  logic [LANES-1:0]            cap_hit,
  input  logic [LANES-1:0][IDX_W-1:0] cap_idx,
  output logic                        sclk,
  output logic [LANES-1:0]            sdata
);
  localparam int NBITS = NBYTES * 8;
  localparam int CW    = $clog2(NBITS + 1);
  localparam int PW    = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int LO    = PERIOD - PERIOD / 2;

  logic [LANES-1:0][NBITS-1:0]  cap_q, cap_d, shr_q, shr_d;
  logic [LANES-1:0][NBYTES-1:0] mask_q, mask_d;
  logic                         busy_q, busy_d, sclk_q, sclk_d;
  logic [PW-1:0]                phase_q, phase_d;
  logic [CW-1:0]                left_q, left_d;
  logic                         complete;

  always_comb begin
    cap_d    = cap_q;
    mask_d   = frame_start ? '0 : mask_q;
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (cap_hit[l] && (cap_idx[l] == IDX_W'(b))) begin
          cap_d[l][NBITS-1-8*b -: 8] = cap_byte;
          mask_d[l][b]               = 1'b1;
        end
      end
    end

    complete = &mask_q;
    shr_d    = shr_q;
    busy_d   = busy_q;
    phase_d  = phase_q;
    left_d   = left_q;
    if (frame_start && complete) begin
      shr_d   = cap_q;
      busy_d  = 1'b1;
      phase_d = '0;
      left_d  = CW'(NBITS);
    end else if (busy_q) begin
      if (phase_q == PW'(PERIOD - 1)) begin
        phase_d = '0;
        for (int l = 0; l < LANES; l++) begin
          shr_d[l] = {shr_q[l][NBITS-2:0], 1'b0};
        end
        left_d = left_q - 1'b1;
        if (left_q == CW'(1)) busy_d = 1'b0;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
    sclk_d = busy_d && (phase_d >= PW'(LO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      mask_q  <= '0;
      shr_q   <= '0;
      busy_q  <= 1'b0;
      phase_q <= '0;
      left_q  <= '0;
      sclk_q  <= 1'b0;
    end else begin
      cap_q   <= cap_d;
      mask_q  <= mask_d;
      shr_q   <= shr_d;
      busy_q  <= busy_d;
      phase_q <= phase_d;
      left_q  <= left_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sdata[l] = shr_q[l][NBITS-1];
  end
endmodule

// File: rtl/ohd_drop_ser.sv
module ohd_drop_ser
  import ohd_pkg::*;
#(
  parameter int OW_PERIOD   = 16,
  parameter int SDCC_PERIOD = 8,
  parameter int LDCC_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] oh_byte,
  input  logic       oh_valid,
  input  logic [3:0] oh_row,
  input  logic [3:0] oh_col,
  input  logic       frame_start,
  output logic       ow_sclk,
  output logic       e1_sdata,
  output logic       e2_sdata,
  output logic       f1_sdata,
  output logic       sdcc_sclk,
  output logic       sdcc_sdata,
  output logic       ldcc_sclk,
  output logic       ldcc_sdata
);
  ohd_sel_t   ow1_sel, ow2_sel, usr_sel, sec_sel, lin_sel;
  logic [2:0] ow_lanes;

  ohd_pos_decode dec_i (
    .oh_valid (oh_valid),
    .oh_row   (oh_row),
    .oh_col   (oh_col),
    .ow1_sel  (ow1_sel),
    .ow2_sel  (ow2_sel),
    .usr_sel  (usr_sel),
    .sec_sel  (sec_sel),
    .lin_sel  (lin_sel)
  );

  // Lane 0: first orderwire, lane 1: second orderwire, lane 2: user byte
  ohd_ser_chan #(.LANES(3), .NBYTES(1), .PERIOD(OW_PERIOD)) ow_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cap_byte    (oh_byte),
    .cap_hit     ({usr_sel.hit, ow2_sel.hit, ow1_sel.hit}),
    .cap_idx     ({usr_sel.idx, ow2_sel.idx, ow1_sel.idx}),
    .sclk        (ow_sclk),
    .sdata       (ow_lanes)
  );

  ohd_ser_chan #(.LANES(1), .NBYTES(3), .PERIOD(SDCC_PERIOD)) sec_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cap_byte    (oh_byte),
    .cap_hit     (sec_sel.hit),
    .cap_idx     (sec_sel.idx),
    .sclk        (sdcc_sclk),
    .sdata       (sdcc_sdata)
  );

  ohd_ser_chan #(.LANES(1), .NBYTES(9), .PERIOD(LDCC_PERIOD)) lin_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cap_byte    (oh_byte),
    .cap_hit     (lin_sel.hit),
    .cap_idx     (lin_sel.idx),
    .sclk        (ldcc_sclk),
    .sdata       (ldcc_sdata)
  );

  assign e1_sdata = ow_lanes[0];
  assign e2_sdata = ow_lanes[1];
  assign f1_sdata = ow_lanes[2];
endmodule

// File: rtl/ohd_drop_ser_chk.sv
module ohd_drop_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic ow_sclk,
  input logic e1_sdata,
  input logic e2_sdata,
  input logic f1_sdata,
  input logic sdcc_sclk,
  input logic sdcc_sdata,
  input logic ldcc_sclk,
  input logic ldcc_sdata
);
  logic       seen_fs;
  logic       ow_p, sd_p, ld_p;
  logic [6:0] ow_n, sd_n, ld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_fs <= 1'b0;
      ow_p <= 1'b0; sd_p <= 1'b0; ld_p <= 1'b0;
      ow_n <= '0;   sd_n <= '0;   ld_n <= '0;
    end else begin
      if (frame_start) seen_fs <= 1'b1;
      ow_p <= ow_sclk; sd_p <= sdcc_sclk; ld_p <= ldcc_sclk;
      ow_n <= frame_start ? '0 : ow_n + 7'(ow_sclk && !ow_p);
      sd_n <= frame_start ? '0 : sd_n + 7'(sdcc_sclk && !sd_p);
      ld_n <= frame_start ? '0 : ld_n + 7'(ldcc_sclk && !ld_p);
    end
  end

  // R5
  e1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ow_sclk |-> $stable(e1_sdata));
  // R5
  e2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ow_sclk |-> $stable(e2_sdata));
  // R5
  f1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ow_sclk |-> $stable(f1_sdata));
  // R5
  sdcc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) sdcc_sclk |-> $stable(sdcc_sdata));
  // R5
  ldcc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ldcc_sclk |-> $stable(ldcc_sdata));
  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fs |-> (!ow_sclk && !sdcc_sclk && !ldcc_sclk));
  // R2
  ow_pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) ow_n <= 7'd8);
  // R3
  sdcc_pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) sd_n <= 7'd24);
  // R4
  ldcc_pulse_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_n <= 7'd72);
endmodule

bind ohd_drop_ser ohd_drop_ser_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .ow_sclk     (ow_sclk),
  .e1_sdata    (e1_sdata),
  .e2_sdata    (e2_sdata),
  .f1_sdata    (f1_sdata),
  .sdcc_sclk   (sdcc_sclk),
  .sdcc_sdata  (sdcc_sdata),
  .ldcc_sclk   (ldcc_sclk),
  .ldcc_sdata  (ldcc_sdata)
);

// File: tb/ohd_drop_ser_tb.sv
module ohd_drop_ser_tb_top;
  localparam int OWP = 16;
  localparam int SDP = 8;
  localparam int LDP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] oh_byte = '0;
  logic       oh_valid = 1'b0;
  logic [3:0] oh_row = '0;
  logic [3:0] oh_col = '0;
  logic       frame_start = 1'b0;
  logic       ow_sclk, e1_sdata, e2_sdata, f1_sdata;
  logic       sdcc_sclk, sdcc_sdata, ldcc_sclk, ldcc_sdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ohd_drop_ser #(.OW_PERIOD(OWP), .SDCC_PERIOD(SDP), .LDCC_PERIOD(LDP)) dut_i (
    .clk(clk), .rst_n(rst_n), .oh_byte(oh_byte), .oh_valid(oh_valid),
    .oh_row(oh_row), .oh_col(oh_col), .frame_start(frame_start),
    .ow_sclk(ow_sclk), .e1_sdata(e1_sdata), .e2_sdata(e2_sdata), .f1_sdata(f1_sdata),
    .sdcc_sclk(sdcc_sclk), .sdcc_sdata(sdcc_sdata),
    .ldcc_sclk(ldcc_sclk), .ldcc_sdata(ldcc_sdata)
  );

  // Port monitor, sampled on the falling system clock edge
  int          cyc = 0;
  int          ow_n, sd_n, ld_n, ow_t, sd_t, ld_t, badh, badp;
  logic [7:0]  e1a, e2a, f1a;
  logic [23:0] sda;
  logic [71:0] lda;
  logic        p_ow = 0, p_sd = 0, p_ld = 0;
  logic [2:0]  p_owd = '0;
  logic        p_sdd = 0, p_ldd = 0;

  always @(negedge clk) begin
    cyc++;
    if (frame_start) begin
      ow_n = 0; sd_n = 0; ld_n = 0; badh = 0; badp = 0;
      e1a = '0; e2a = '0; f1a = '0; sda = '0; lda = '0;
    end else begin
      if (ow_sclk && !p_ow) begin
        if (ow_n != 0 && cyc - ow_t != OWP) badp++;
        ow_t = cyc; ow_n++;
        e1a = {e1a[6:0], e1_sdata}; e2a = {e2a[6:0], e2_sdata}; f1a = {f1a[6:0], f1_sdata};
      end
      if (sdcc_sclk && !p_sd) begin
        if (sd_n != 0 && cyc - sd_t != SDP) badp++;
        sd_t = cyc; sd_n++; sda = {sda[22:0], sdcc_sdata};
      end
      if (ldcc_sclk && !p_ld) begin
        if (ld_n != 0 && cyc - ld_t != LDP) badp++;
        ld_t = cyc; ld_n++; lda = {lda[70:0], ldcc_sdata};
      end
      if (ow_sclk && p_ow && ({e1_sdata, e2_sdata, f1_sdata} != p_owd)) badh++;
      if (sdcc_sclk && p_sd && (sdcc_sdata != p_sdd)) badh++;
      if (ldcc_sclk && p_ld && (ldcc_sdata != p_ldd)) badh++;
    end
    p_ow = ow_sclk; p_sd = sdcc_sclk; p_ld = ldcc_sclk;
    p_owd = {e1_sdata, e2_sdata, f1_sdata}; p_sdd = sdcc_sdata; p_ldd = ldcc_sdata;
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic put(input int r, input int c, input logic [7:0] b, input bit v);
    oh_row = 4'(r); oh_col = 4'(c); oh_byte = b; oh_valid = v;
    tick();
    oh_valid = 1'b0;
    tick();
  endtask

  // Expected content of the frame now waiting in the capture buffers
  bit          x_ow = 0, x_sd = 0, x_ld = 0;
  logic [7:0]  x_e1, x_e2, x_f1;
  logic [95:0] x_d;

  task automatic do_frame(input logic [7:0] e1, input logic [7:0] f1, input logic [7:0] e2,
                          input logic [95:0] d, input bit ow_ok, input bit sd_ok,
                          input bit ld_ok, input bit junk, input string lbl);
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    put(1, 1, e1, 1'b1);
    if (ow_ok) put(1, 2, f1, 1'b1);
    put(8, 2, e2, 1'b1);
    for (int i = 0; i < 12; i++) begin
      if (!((i == 1 && !sd_ok) || (i == 11 && !ld_ok))) begin
        if (i < 3) put(2, i, d[95-8*i -: 8], 1'b1);
        else       put(5 + (i - 3) / 3, (i - 3) % 3, d[95-8*i -: 8], 1'b1);
      end
    end
    if (junk) begin
      put(1, 1, 8'hFF, 1'b0);
      put(2, 0, 8'h00, 1'b0);
      put(6, 1, 8'h5A, 1'b0);
      put(1, 0, 8'hEE, 1'b1);
      put(2, 3, 8'h77, 1'b1);
      put(4, 1, 8'h99, 1'b1);
      put(8, 1, 8'h11, 1'b1);
    end
    repeat (420) tick();
    // Output of this frame carries the bytes captured in the previous frame
    chk(ow_n == (x_ow ? 8 : 0), {"R2 R7 ", lbl}, 96'(ow_n), 96'(x_ow ? 8 : 0));
    chk(sd_n == (x_sd ? 24 : 0), {"R3 R7 ", lbl}, 96'(sd_n), 96'(x_sd ? 24 : 0));
    chk(ld_n == (x_ld ? 72 : 0), {"R4 R7 ", lbl}, 96'(ld_n), 96'(x_ld ? 72 : 0));
    if (x_ow) begin
      chk(e1a == x_e1, {"R1 R9 first orderwire ", lbl}, 96'(e1a), 96'(x_e1));
      chk(e2a == x_e2, {"R1 R9 second orderwire ", lbl}, 96'(e2a), 96'(x_e2));
      chk(f1a == x_f1, {"R1 R9 user byte ", lbl}, 96'(f1a), 96'(x_f1));
    end
    if (x_sd) chk(sda == x_d[95:72], {"R3 R9 ", lbl}, 96'(sda), 96'(x_d[95:72]));
    if (x_ld) chk(lda == x_d[71:0], {"R4 R9 ", lbl}, 96'(lda), 96'(x_d[71:0]));
    chk(badh == 0, {"R5 ", lbl}, 96'(badh), 96'(0));
    chk(badp == 0, {"R10 ", lbl}, 96'(badp), 96'(0));
    chk(!ow_sclk && !sdcc_sclk && !ldcc_sclk, {"R6 idle after burst ", lbl},
        96'({ow_sclk, sdcc_sclk, ldcc_sclk}), 96'(0));
    x_ow = ow_ok; x_sd = sd_ok; x_ld = ld_ok;
    x_e1 = e1; x_e2 = e2; x_f1 = f1; x_d = d;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk({ow_sclk, e1_sdata, e2_sdata, f1_sdata, sdcc_sclk, sdcc_sdata, ldcc_sclk, ldcc_sdata} == '0,
        "R6 reset outputs", 96'({ow_sclk, e1_sdata, e2_sdata, f1_sdata,
        sdcc_sclk, sdcc_sdata, ldcc_sclk, ldcc_sdata}), 96'(0));
    rst_n = 1'b1;
    repeat (20) tick();
    chk(!ow_sclk && !sdcc_sclk && !ldcc_sclk, "R6 idle before first frame",
        96'({ow_sclk, sdcc_sclk, ldcc_sclk}), 96'(0));
  endtask

  task automatic t_first_frame();
    do_frame(8'hA5, 8'h3C, 8'h81, 96'h0123_4567_89AB_CDEF_1357_9BDF, 1, 1, 1, 0, "R7 empty first");
  endtask

  task automatic t_normal();
    do_frame(8'h5A, 8'hC3, 8'h7E, 96'hFEDC_BA98_7654_3210_ECA8_6420, 1, 1, 1, 1, "normal");
  endtask

  task automatic t_junk_follow();
    do_frame(8'h01, 8'h80, 8'hF0, 96'h8000_0000_0000_0000_0000_0001, 0, 0, 1, 0, "R8 after junk");
  endtask

  task automatic t_partial_follow();
    do_frame(8'hFF, 8'h00, 8'h69, 96'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F, 1, 1, 1, 0, "R7 partial");
  endtask

  task automatic t_flush();
    do_frame(8'h00, 8'h00, 8'h00, 96'h0, 0, 0, 0, 0, "final");
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_normal();
    t_junk_follow();
    t_partial_follow();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule